// File: doc/BRIEF.md
# Flash Command Lock Guard

This block stands between a command register and a page-organised flash array. Software writes one 32-bit command word. The guard decides whether the command may run, given the per-region lock bits and a one-way security bit. If it may run, the guard sends a one-cycle start strobe to the array sequencer. If not, it drops the command and sets a sticky error flag. The array has 2048 pages, 11 page-address bits in all. The top bit selects one of two banks. Every 64 consecutive pages share one lock bit, so the region index is page bits [10:6] and there are 32 regions.

A busy counter stands in for the array. It holds the ready flag low for a page-program time, a full-erase time or a short lock-update time, each set by a parameter. A dedicated erase input acts as a recovery path. While it is high it wipes every lock bit. Its rising edge queues a full erase that ignores the locks. When that erase finishes, the security bit is cleared.

Command word fields are as follows. Bits [31:24] hold the key, which must be 0xA5. Bits [18:8] hold the page. Bits [3:0] hold the opcode: 1 program page, 2 set lock, 3 clear lock, 4 full erase, 5 set security. The status word stat_q is {security, cmd_err, lock_err, ready}, with ready at bit 0.

Top module: `flash_lock_guard`

## Requirements
- R1: A command word whose key bits [31:24] differ from 0xA5 is ignored: no start, no lock change and no busy time. It sets cmd_err (stat_q[2]).
- R2: A program command (opcode 1) to an unlocked region is accepted. In the next cycle array_start is high for exactly one cycle, with array_op=01 and array_page equal to word bits [18:8]. Ready (stat_q[0]) is then low for PROG_CYCLES cycles.
- R3: A program command to a page whose region (page bits [10:6]) is locked does not start the array. It leaves ready high and sets lock_err (stat_q[1]).
- R4: Opcode 2 sets and opcode 3 clears lock_q[region] in the next cycle. Each holds ready low for BIT_CYCLES cycles and raises no start.
- R5: A full-erase command (opcode 4) is rejected with lock_err while any lock bit is set. Otherwise it starts the array with array_op=10 and holds ready low for ERASE_CYCLES cycles.
- R6: A keyed command is ignored and sets cmd_err in two cases: when it arrives while ready is low, or when its opcode is not 1 to 5.
- R7: lock_err and cmd_err are sticky. A cycle with stat_rd high clears them on the next edge, except that an error raised in that same cycle stays set.
- R8: irq is high when lock_err is set and mode bit 0 is set, or when cmd_err is set and mode bit 1 is set. The mode bits are loaded from mode_din when mode_wr is high.
- R9: The security bit (stat_q[3]) is set only by opcode 5. No command clears it. It clears only when a full erase launched by the erase pin completes.
- R10: Every cycle in which erase_pin is high clears all lock bits. A rising edge of erase_pin drops ready on the next edge and queues a full erase. That erase starts once any running operation ends, regardless of locks.
- R11: After reset ready is 1, errors, security, lock bits, irq and array_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Key, page and opcode |
| mode_wr | input | 1 | Mode register write strobe |
| mode_din | input | 2 | Interrupt enables: bit 0 lock error, bit 1 command error |
| stat_rd | input | 1 | Status read, clears sticky errors |
| erase_pin | input | 1 | External recovery erase input |
| stat_q | output | 4 | {security, cmd_err, lock_err, ready} |
| irq | output | 1 | Masked error interrupt |
| lock_q | output | 32 | Region lock bits |
| array_start | output | 1 | One-cycle start strobe to the array sequencer |
| array_op | output | 2 | 01 program page, 10 full erase |
| array_page | output | 11 | Page address for a program |

## Verification
The stimulus covers several cases that the guard must tell apart: programs to unlocked and locked regions, including pages on both sides of a region boundary and in the upper bank; a full erase with and without locks present; wrong keys, bad opcodes and commands issued during busy time; and a status read that collides with a new error. The erase pin is pulsed while locks and security are set and an operation is running. This shows the difference between the immediate lock wipe and the deferred, lock-blind erase that clears security. A behavioural model in the bench predicts every output on every cycle, so a start strobe that lands one cycle early or late is caught as well as a wrong value.

// File: rtl/flash_lock_guard.sv
module flash_lock_guard #(
  parameter logic [7:0] KEY          = 8'hA5,
  parameter int         PAGE_W       = 11,
  parameter int         REG_SHIFT    = 6,
  parameter int         PROG_CYCLES  = 300000,
  parameter int         ERASE_CYCLES = 750000,
  parameter int         BIT_CYCLES   = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_wr,
  input  logic [31:0]                         cmd_word,
  input  logic                                mode_wr,
  input  logic [1:0]                          mode_din,
  input  logic                                stat_rd,
  input  logic                                erase_pin,
  output logic [3:0]                          stat_q,
  output logic                                irq,
  output logic [(1<<(PAGE_W-REG_SHIFT))-1:0]  lock_q,
  output logic                                array_start,
  output logic [1:0]                          array_op,
  output logic [PAGE_W-1:0]                   array_page
);
  localparam int NREG  = 1 << (PAGE_W - REG_SHIFT);
  localparam int RW    = PAGE_W - REG_SHIFT;
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ?
                         ((PROG_CYCLES > BIT_CYCLES) ? PROG_CYCLES : BIT_CYCLES) :
                         ((ERASE_CYCLES > BIT_CYCLES) ? ERASE_CYCLES : BIT_CYCLES);
  localparam int CW    = $clog2(MAXC + 1);

  localparam logic [3:0] OP_PROG = 4'd1;
  localparam logic [3:0] OP_SETL = 4'd2;
  localparam logic [3:0] OP_CLRL = 4'd3;
  localparam logic [3:0] OP_ERAS = 4'd4;
  localparam logic [3:0] OP_SSEC = 4'd5;

  logic [CW-1:0]   cnt;
  logic            pin_d, pin_req, pin_mode;
  logic            security, lock_err, cmd_err;
  logic [1:0]      irq_en;
  logic [NREG-1:0] locks;

  wire [3:0]        opc    = cmd_word[3:0];
  wire [PAGE_W-1:0] page   = cmd_word[8 +: PAGE_W];
  wire [RW-1:0]     region = page[PAGE_W-1 -: RW];
  wire              key_ok = cmd_word[31:24] == KEY;
  wire              idle   = (cnt == '0) && !pin_req;
  wire              op_ok  = (opc >= OP_PROG) && (opc <= OP_SSEC);
  wire              keyed  = cmd_wr && key_ok && idle && op_ok;
  wire              lk_hit = (opc == OP_PROG && locks[region]) ||
                             (opc == OP_ERAS && |locks);
  wire              lerr_set  = keyed && lk_hit;
  wire              cerr_set  = cmd_wr && !(key_ok && idle && op_ok);
  wire              go        = keyed && !lk_hit;
  wire              pin_start = pin_req && (cnt == '0);
  wire              pin_rise  = erase_pin && !pin_d;
  wire              last      = cnt == CW'(1);
  wire [7:0]        unused_bits = {cmd_word[23:8+PAGE_W], cmd_word[7:4]};

  assign stat_q = {security, cmd_err, lock_err, idle};
  assign irq    = (lock_err && irq_en[0]) || (cmd_err && irq_en[1]);
  assign lock_q = locks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      pin_d <= 1'b0;
      pin_req <= 1'b0;
      pin_mode <= 1'b0;
      array_start <= 1'b0;
      array_op <= 2'b00;
      array_page <= '0;
    end else begin
      pin_d <= erase_pin;
      pin_req <= (pin_req && !pin_start) || pin_rise;
      array_start <= 1'b0;
      if (pin_start) begin
        cnt <= CW'(ERASE_CYCLES);
        pin_mode <= 1'b1;
        array_start <= 1'b1;
        array_op <= 2'b10;
        array_page <= '0;
      end else if (go) begin
        case (opc)
          OP_PROG: begin
            cnt <= CW'(PROG_CYCLES);
            array_start <= 1'b1;
            array_op <= 2'b01;
            array_page <= page;
          end
          OP_ERAS: begin
            cnt <= CW'(ERASE_CYCLES);
            array_start <= 1'b1;
            array_op <= 2'b10;
            array_page <= '0;
          end
          default: cnt <= CW'(BIT_CYCLES);
        endcase
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (last) pin_mode <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locks <= '0;
      security <= 1'b0;
      lock_err <= 1'b0;
      cmd_err <= 1'b0;
      irq_en <= 2'b00;
    end else begin
      if (erase_pin) locks <= '0;
      else if (go && opc == OP_SETL) locks[region] <= 1'b1;
      else if (go && opc == OP_CLRL) locks[region] <= 1'b0;

      if (last && pin_mode) security <= 1'b0;
      else if (go && opc == OP_SSEC) security <= 1'b1;

      if (lerr_set) lock_err <= 1'b1;
      else if (stat_rd) lock_err <= 1'b0;

      if (cerr_set) cmd_err <= 1'b1;
      else if (stat_rd) cmd_err <= 1'b0;

      if (mode_wr) irq_en <= mode_din;
    end
  end
endmodule

// File: rtl/flash_lock_guard_chk.sv
module flash_lock_guard_chk #(
  parameter logic [7:0] CHK_KEY = 8'hA5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_word,
  input logic        stat_rd,
  input logic        erase_pin,
  input logic [3:0]  stat_q,
  input logic [31:0] lock_q,
  input logic        array_start
);
  AST_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    array_start |-> !stat_q[0]); // R2

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    array_start |=> !array_start); // R2

  AST_LOCKED_PROG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[31:24] == CHK_KEY && cmd_word[3:0] == 4'd1 && stat_q[0]
     && lock_q[cmd_word[18:14]]) |=> (!array_start && stat_q[1])); // R3

  AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !stat_q[0]) |=> stat_q[2]); // R6

  AST_LOCK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] && !stat_rd) |=> stat_q[1]); // R7

  AST_SECURITY_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[3]) |-> ($past(cmd_wr) && $past(cmd_word[3:0]) == 4'd5)); // R9

  AST_PIN_WIPES_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pin |=> (lock_q == 32'd0)); // R10
endmodule

bind flash_lock_guard flash_lock_guard_chk chk_i (.*);

// File: tb/flash_lock_guard_tb.sv
module flash_lock_guard_tb_top;
  localparam int PC = 20, EC = 50, BC = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_wr = 1'b0, mode_wr = 1'b0, stat_rd = 1'b0, erase_pin = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0]  mode_din = '0;
  logic [3:0]  stat_q;
  logic        irq, array_start;
  logic [31:0] lock_q;
  logic [1:0]  array_op;
  logic [10:0] array_page;

  flash_lock_guard #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC), .BIT_CYCLES(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .mode_wr(mode_wr), .mode_din(mode_din), .stat_rd(stat_rd), .erase_pin(erase_pin),
    .stat_q(stat_q), .irq(irq), .lock_q(lock_q), .array_start(array_start),
    .array_op(array_op), .array_page(array_page));

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;

  // behavioural reference state
  int        m_cnt;
  bit        m_preq, m_pind, m_pmode, m_sec, m_lerr, m_cerr, m_start;
  bit [1:0]  m_en, m_op;
  bit [31:0] m_lock;
  int        m_page;
  int        t_op, t_pg, t_rg;
  bit        t_idle, t_sp, t_go, t_le, t_ce, t_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_preq = 0; m_pind = 0; m_pmode = 0; m_sec = 0;
      m_lerr = 0; m_cerr = 0; m_start = 0; m_en = 0; m_lock = 0; m_op = 0; m_page = 0;
    end else begin
      t_op = int'(cmd_word[3:0]);
      t_pg = int'(cmd_word[18:8]);
      t_rg = t_pg / 64;
      t_idle = (m_cnt == 0) && !m_preq;
      t_sp = m_preq && (m_cnt == 0);
      t_ok = (cmd_word[31:24] == 8'hA5) && t_idle && t_op >= 1 && t_op <= 5;
      t_ce = cmd_wr && !t_ok;
      t_le = 0; t_go = 0;
      if (cmd_wr && t_ok) begin
        if ((t_op == 1 && m_lock[t_rg]) || (t_op == 4 && m_lock != 0)) t_le = 1;
        else t_go = 1;
      end
      m_start = 0;
      if (t_sp) begin
        m_start = 1; m_op = 2'b10; m_cnt = EC; m_pmode = 1;
      end else if (t_go) begin
        case (t_op)
          1: begin m_start = 1; m_op = 2'b01; m_page = t_pg; m_cnt = PC; end
          2: begin m_lock[t_rg] = 1; m_cnt = BC; end
          3: begin m_lock[t_rg] = 0; m_cnt = BC; end
          4: begin m_start = 1; m_op = 2'b10; m_cnt = EC; end
          default: begin m_sec = 1; m_cnt = BC; end
        endcase
      end else if (m_cnt > 0) begin
        if (m_cnt == 1 && m_pmode) begin m_sec = 0; m_pmode = 0; end
        m_cnt = m_cnt - 1;
      end
      if (erase_pin) m_lock = 0;
      m_preq = (m_preq && !t_sp) || (erase_pin && !m_pind);
      m_pind = erase_pin;
      if (t_le) m_lerr = 1; else if (stat_rd) m_lerr = 0;
      if (t_ce) m_cerr = 1; else if (stat_rd) m_cerr = 0;
      if (mode_wr) m_en = mode_din;
    end
  end

  task automatic cmp(input string tag, input longint act, input longint exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      vectors++;
      cmp("R2 R4 R5 R10 ready", stat_q[0], (m_cnt == 0) && !m_preq);
      cmp("R3 R5 lock_err", stat_q[1], m_lerr);
      cmp("R1 R6 R7 cmd_err", stat_q[2], m_cerr);
      cmp("R9 security", stat_q[3], m_sec);
      cmp("R8 irq", irq, (m_lerr && m_en[0]) || (m_cerr && m_en[1]));
      cmp("R4 R10 lock_q", lock_q, m_lock);
      cmp("R2 R5 array_start", array_start, m_start);
      if (m_start) begin
        cmp("R2 R5 array_op", array_op, m_op);
        if (m_op == 2'b01) cmp("R2 array_page", array_page, m_page);
      end
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [31:0] w(input logic [7:0] k, input int pg, input int op);
    return {k, 5'd0, 11'(pg), 4'd0, 4'(op)};
  endfunction

  task automatic issue(input logic [31:0] word);
    cmd_wr = 1'b1; cmd_word = word;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_word = '0;
  endtask

  task automatic rd;
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wait_ready;
    while (!stat_q[0]) @(negedge clk);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    cmp(tag, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset stat", stat_q, 4'b0001);
    chk("R11 reset locks", lock_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset irq", irq, 0);

    issue(w(8'h5B, 5, 1));                 // R1 wrong key
    chk("R1 key rejected", {stat_q[2], stat_q[0]}, 2'b11);
    rd;
    chk("R7 read clears", stat_q[2], 0);

    issue(w(8'hA5, 5, 1));                 // R2 program unlocked
    chk("R2 start seen", array_start, 1);
    issue(w(8'hA5, 6, 1));                 // R6 while busy
    chk("R6 busy cmd", stat_q[2], 1);
    wait_ready; rd;

    issue(w(8'hA5, 70, 2));                // R4 lock region 1
    chk("R4 lock set", lock_q[1], 1);
    wait_ready;
    issue(w(8'hA5, 100, 1));               // R3 locked program
    chk("R3 locked blocked", {stat_q[1], stat_q[0], array_start}, 3'b110);
    mode_wr = 1'b1; mode_din = 2'b01; @(negedge clk); mode_wr = 1'b0;
    chk("R8 irq on lock err", irq, 1);
    issue(w(8'hA5, 63, 1)); wait_ready;    // region 0 boundary
    issue(w(8'hA5, 128, 1)); wait_ready;   // region 2 boundary
    issue(w(8'hA5, 0, 4));                 // R5 erase rejected
    chk("R5 erase blocked", array_start, 0);
    rd;
    chk("R8 irq cleared", irq, 0);
    issue(w(8'hA5, 64, 3)); wait_ready;
    chk("R4 lock cleared", lock_q[1], 0);
    issue(w(8'hA5, 0, 4));                 // R5 erase runs
    chk("R5 erase start", {array_start, array_op}, 3'b110);
    wait_ready;

    issue(w(8'hA5, 0, 7));                 // R6 bad opcode
    mode_wr = 1'b1; mode_din = 2'b10; @(negedge clk); mode_wr = 1'b0;
    chk("R8 irq cmd err", irq, 1);
    stat_rd = 1'b1; cmd_wr = 1'b1; cmd_word = w(8'h00, 0, 1);
    @(negedge clk);
    stat_rd = 1'b0; cmd_wr = 1'b0;
    chk("R7 set wins over read", stat_q[2], 1);
    rd;

    issue(w(8'hA5, 0, 5)); wait_ready;     // R9 security
    chk("R9 security set", stat_q[3], 1);
    issue(w(8'hA5, 2047, 2)); wait_ready;  // upper bank region 31
    issue(w(8'hA5, 10, 2)); wait_ready;
    chk("R4 upper bank lock", lock_q, 32'h8000_0001);
    issue(w(8'hA5, 300, 1));               // running op when pin rises
    erase_pin = 1'b1; @(negedge clk);
    chk("R10 locks wiped", lock_q, 0);
    erase_pin = 1'b0;
    chk("R9 security held during erase", stat_q[3], 1);
    repeat (PC + EC + 5) @(negedge clk);
    chk("R9 security cleared by pin erase", stat_q[3], 0);
    chk("R10 ready after pin erase", stat_q[0], 1);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule